// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block frees an I2C bus that a target has left stuck, typically with SDA held low in the middle of a byte. It drives the two open-drain lines directly. Each line has an output enable that pulls the line low when set; when it is clear, the line is left to its pull-up. A single-cycle start request makes the block take over both lines, with SDA left released high. It then clocks out a full address frame: seven address bits, the read/write bit and the acknowledge slot. Any target that was part-way through a transfer can therefore finish shifting and let go of SDA.

Before each clock pulse the sequencer reads back SCL. If a target is stretching the clock, the sequencer waits in fixed poll intervals, up to a bounded number of polls. When that limit is reached it carries on anyway and records the event in a sticky flag. After the last pulse it forces a STOP condition, releases both lines and pulses done. All timing comes from one parameter giving clock cycles per microsecond, so every phase lasts a whole number of cycles.

Top module: `i2c_bus_recovery`

## Requirements
- R1: A start request seen while idle begins a sequence on the next edge. busy_o is high from the cycle after that edge up to and including the done cycle. Sequence length in cycles is 9·(2H+1) + W·(2H+1) + 3H + 1, where H = 5·CYC_PER_US and W is the total number of stretch polls taken.
- R2: Exactly 9 clock pulses are issued. Each holds scl_oe_o high for H cycles and then low for H cycles. sda_oe_o stays low for every pulse.
- R3: Before each pulse there is one sampling cycle that reads SCL through a two-stage synchronizer. If SCL reads low, the block waits 2H cycles (one 10 µs poll) and samples again. Each poll therefore adds 2H+1 cycles.
- R4: If SCL still reads low after 50 polls for one pulse, the block issues the pulse anyway and sets stretch_to_o. A read of high at the sampling cycle after the 50th poll sets no flag.
- R5: The STOP sequence runs as follows: scl_oe_o high for H cycles, then sda_oe_o also high for H cycles, then scl_oe_o low with sda_oe_o still high for H cycles, then both low. sda_oe_o never rises while scl_oe_o is low, and never falls while scl_oe_o is high.
- R6: done_o is high for exactly one cycle, the first cycle in which both enables are low after the STOP. busy_o is low in the following cycle.
- R7: stretch_to_o is sticky while idle. It is cleared on the edge that accepts a new start.
- R8: A start request while busy_o is high has no effect. The running sequence keeps its length and pulse count.
- R9: While reset is asserted, and after it is released, both enables are low and the block is idle. Reset asserts asynchronously and is released synchronously.
- R10: An enable value of 1 pulls its line low; 0 releases it. All phase lengths are whole multiples of CYC_PER_US cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| start_i | input | 1 | Request to begin a recovery sequence |
| scl_i | input | 1 | Read-back of the SCL line level |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| stretch_to_o | output | 1 | Sticky flag: a clock-stretch wait hit its cap |
| scl_oe_o | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
A wrong pulse or poll counter shows at the ports as a done pulse that arrives a whole multiple of 2H+1 cycles early or late. The bench compares the exact sequence length, so such a fault is visible on the first run. A decode fault in the STOP states shows as an SDA enable edge while SCL is in the wrong state, or as a wrong count of enabled cycles, within the 3H cycles before done. A flag that is not sticky, or not cleared, shows at the start of the very next sequence.

// File: rtl/rcv_pkg.sv
package rcv_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CHECK,
    ST_WAIT,
    ST_LOW,
    ST_HIGH,
    ST_STOP_SCL,
    ST_STOP_SDA,
    ST_STOP_REL,
    ST_DONE
  } rcv_state_e;
endpackage

// File: rtl/rcv_sync.sv
module rcv_sync #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic meta_q, stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      stab_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      stab_q <= meta_q;
    end
  end

  assign q_o = stab_q;
endmodule

// File: rtl/rcv_us_timer.sv
module rcv_us_timer #(
  parameter int CYC_PER_US = 100,
  parameter int MAX_US     = 10
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        load_i,
  input  logic [$clog2(MAX_US+1)-1:0] len_us_i,
  output logic                        expire_o
);
  localparam int UW = $clog2(MAX_US + 1);
  localparam int CW = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;

  logic [CW-1:0] sub_q, sub_d;
  logic [UW-1:0] us_q, us_d;
  logic          en;

  always_comb begin
    sub_d = sub_q;
    us_d  = us_q;
    en    = 1'b0;
    if (load_i) begin
      en    = 1'b1;
      sub_d = CW'(CYC_PER_US - 1);
      us_d  = len_us_i - UW'(1);
    end else if (sub_q != '0) begin
      en    = 1'b1;
      sub_d = sub_q - CW'(1);
    end else if (us_q != '0) begin
      en    = 1'b1;
      sub_d = CW'(CYC_PER_US - 1);
      us_d  = us_q - UW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_q <= '0;
      us_q  <= '0;
    end else if (en) begin
      sub_q <= sub_d;
      us_q  <= us_d;
    end
  end

  assign expire_o = (sub_q == '0) && (us_q == '0);
endmodule

// File: rtl/rcv_ctrl.sv
module rcv_ctrl
  import rcv_pkg::*;
#(
  parameter int NUM_PULSES = 9,
  parameter int MAX_POLLS  = 50,
  parameter int HALF_US    = 5,
  parameter int POLL_US    = 10,
  parameter int UW         = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          scl_hi_i,
  input  logic          expire_i,
  output logic          load_o,
  output logic [UW-1:0] len_us_o,
  output logic          scl_oe_o,
  output logic          sda_oe_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          stretch_to_o
);
  localparam int PW = $clog2(NUM_PULSES + 1);
  localparam int QW = $clog2(MAX_POLLS + 1);

  rcv_state_e    state_q, state_d;
  logic [PW-1:0] pulse_q, pulse_d;
  logic [QW-1:0] poll_q, poll_d;
  logic          flag_q, flag_d;
  logic          scl_oe_d, sda_oe_d;

  always_comb begin
    state_d  = state_q;
    pulse_d  = pulse_q;
    poll_d   = poll_q;
    flag_d   = flag_q;
    load_o   = 1'b0;
    len_us_o = UW'(HALF_US);
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = ST_CHECK;
        pulse_d = '0;
        poll_d  = '0;
        flag_d  = 1'b0;
      end
      ST_CHECK: begin
        if (scl_hi_i || (poll_q == QW'(MAX_POLLS))) begin
          if (!scl_hi_i) flag_d = 1'b1;
          poll_d  = '0;
          state_d = ST_LOW;
          load_o  = 1'b1;
        end else begin
          poll_d   = poll_q + QW'(1);
          state_d  = ST_WAIT;
          load_o   = 1'b1;
          len_us_o = UW'(POLL_US);
        end
      end
      ST_WAIT: if (expire_i) state_d = ST_CHECK;
      ST_LOW: if (expire_i) begin
        state_d = ST_HIGH;
        load_o  = 1'b1;
      end
      ST_HIGH: if (expire_i) begin
        if (pulse_q == PW'(NUM_PULSES - 1)) begin
          state_d = ST_STOP_SCL;
          load_o  = 1'b1;
        end else begin
          pulse_d = pulse_q + PW'(1);
          state_d = ST_CHECK;
        end
      end
      ST_STOP_SCL: if (expire_i) begin
        state_d = ST_STOP_SDA;
        load_o  = 1'b1;
      end
      ST_STOP_SDA: if (expire_i) begin
        state_d = ST_STOP_REL;
        load_o  = 1'b1;
      end
      ST_STOP_REL: if (expire_i) state_d = ST_DONE;
      ST_DONE:     state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  // Line enables decoded from the next state and registered: glitch-free pins
  assign scl_oe_d = (state_d == ST_LOW) || (state_d == ST_STOP_SCL) ||
                    (state_d == ST_STOP_SDA);
  assign sda_oe_d = (state_d == ST_STOP_SDA) || (state_d == ST_STOP_REL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      pulse_q  <= '0;
      poll_q   <= '0;
      flag_q   <= 1'b0;
      scl_oe_o <= 1'b0;
      sda_oe_o <= 1'b0;
      busy_o   <= 1'b0;
      done_o   <= 1'b0;
    end else begin
      state_q  <= state_d;
      pulse_q  <= pulse_d;
      poll_q   <= poll_d;
      flag_q   <= flag_d;
      scl_oe_o <= scl_oe_d;
      sda_oe_o <= sda_oe_d;
      busy_o   <= (state_d != ST_IDLE);
      done_o   <= (state_d == ST_DONE);
    end
  end

  assign stretch_to_o = flag_q;
endmodule

// File: rtl/i2c_bus_recovery.sv
module i2c_bus_recovery #(
  parameter int CYC_PER_US     = 100,
  parameter int PERIOD_US      = 10,
  parameter int NUM_PULSES     = 9,
  parameter int STRETCH_CAP_US = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic scl_i,
  output logic busy_o,
  output logic done_o,
  output logic stretch_to_o,
  output logic scl_oe_o,
  output logic sda_oe_o
);
  localparam int HALF_US   = PERIOD_US / 2;
  localparam int MAX_POLLS = STRETCH_CAP_US / PERIOD_US;
  localparam int UW        = $clog2(PERIOD_US + 1);

  logic          rst_meta_q, rst_sync_q;
  logic          scl_hi;
  logic          load;
  logic [UW-1:0] len_us;
  logic          expire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  rcv_sync #(.RST_VAL(1'b1)) u_scl_sync (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .d_i   (scl_i),
    .q_o   (scl_hi)
  );

  rcv_us_timer #(.CYC_PER_US(CYC_PER_US), .MAX_US(PERIOD_US)) u_timer (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .load_i   (load),
    .len_us_i (len_us),
    .expire_o (expire)
  );

  rcv_ctrl #(
    .NUM_PULSES (NUM_PULSES),
    .MAX_POLLS  (MAX_POLLS),
    .HALF_US    (HALF_US),
    .POLL_US    (PERIOD_US),
    .UW         (UW)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_sync_q),
    .start_i      (start_i),
    .scl_hi_i     (scl_hi),
    .expire_i     (expire),
    .load_o       (load),
    .len_us_o     (len_us),
    .scl_oe_o     (scl_oe_o),
    .sda_oe_o     (sda_oe_o),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .stretch_to_o (stretch_to_o)
  );
endmodule

// File: rtl/rcv_checker.sv
module rcv_checker (
  input logic clk,
  input logic rst_n,
  input logic busy_o,
  input logic done_o,
  input logic stretch_to_o,
  input logic scl_oe_o,
  input logic sda_oe_o
);
  a_r5_sda_pull_under_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe_o) |-> scl_oe_o);

  a_r5_sda_release_after_scl: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe_o) |-> !scl_oe_o);

  a_r6_done_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r6_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_o);

  a_r8_busy_until_done: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o) |=> busy_o);

  a_r9_idle_lines_released: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!scl_oe_o && !sda_oe_o));

  a_r7_flag_set_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stretch_to_o) |-> busy_o);
endmodule

bind i2c_bus_recovery rcv_checker u_rcv_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .stretch_to_o (stretch_to_o),
  .scl_oe_o     (scl_oe_o),
  .sda_oe_o     (sda_oe_o)
);

// File: tb/i2c_bus_recovery_test.sv
module i2c_bus_recovery_test;
  localparam int CYC    = 2;
  localparam int H      = 5 * CYC;
  localparam int W      = 2 * H + 1;
  localparam int CAP    = 50;
  localparam int PULSES = 9;
  localparam int NV     = 5;
  localparam int VEC_POLLS [NV] = '{0, 1, 3, 7, 50};
  localparam int VEC_FLAG  [NV] = '{0, 0, 0, 0, 0};

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, start;
  logic busy, done, sto, scl_oe, sda_oe;
  wire  scl_line;

  int pe = 0;
  always @(posedge clk) pe <= pe + 1;

  int p0 = 0, rel_lim = 0;
  bit hold_on = 1'b0, hold_all = 1'b0;
  wire stretch = hold_all || (hold_on && ((pe + 1 - p0) < rel_lim));
  assign scl_line = !scl_oe && !stretch;

  i2c_bus_recovery #(.CYC_PER_US(CYC)) uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start),
    .scl_i        (scl_line),
    .busy_o       (busy),
    .done_o       (done),
    .stretch_to_o (sto),
    .scl_oe_o     (scl_oe),
    .sda_oe_o     (sda_oe)
  );

  int checks = 0, fails = 0;
  bit clr = 1'b0;
  int scl_low = 0, sda_low = 0, scl_falls = 0, order_err = 0;
  logic prev_scl = 1'b0, prev_sda = 1'b0;

  always @(posedge clk) begin
    if (clr) begin
      scl_low = 0; sda_low = 0; scl_falls = 0; order_err = 0;
    end else begin
      if (scl_oe) scl_low++;
      if (sda_oe) sda_low++;
      if (scl_oe && !prev_scl) scl_falls++;
      if (sda_oe && !prev_sda && !scl_oe) order_err++;
      if (!sda_oe && prev_sda && scl_oe) order_err++;
    end
    prev_scl = scl_oe;
    prev_sda = sda_oe;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  always @(posedge clk) begin
    if (pe > 100000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", pe, 100000);
      summary();
      $finish;
    end
  end

  task automatic run(input int m, input bit all, input int exp_flag,
                     input int restart_at, input string tag);
    int n, exp_t;
    @(negedge clk);
    clr      = 1'b1;
    p0       = pe + 2;
    hold_on  = (m > 0);
    rel_lim  = m * W - 1 - H;
    hold_all = all;
    @(negedge clk);
    clr   = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 1;
    // R7 flag cleared on the accepting edge; R1 busy from cycle 1
    chk(sto == 1'b0, {tag, " R7 flag cleared at start"}, sto, 0);
    chk(busy == 1'b1, {tag, " R1 busy after start"}, busy, 1);
    while (!done && n < 20000) begin
      @(negedge clk);
      n++;
      start = (n == restart_at);
    end
    start = 1'b0;
    exp_t = PULSES * W + (all ? PULSES * CAP * W : m * W) + 3 * H + 1;
    chk(n == exp_t, {tag, " R1 R3 sequence length"}, n, exp_t);
    chk(sto == exp_flag, {tag, " R4 stretch flag"}, sto, exp_flag);
    chk(scl_falls == PULSES + 1, {tag, " R2 scl pull count"}, scl_falls, PULSES + 1);
    chk(scl_low == (2 * PULSES + 4) * H / 2 + 0 * H, {tag, " R2 R10 scl low cycles"},
        scl_low, (PULSES + 2) * H);
    chk(sda_low == 2 * H, {tag, " R2 R5 sda low cycles"}, sda_low, 2 * H);
    chk(order_err == 0, {tag, " R5 stop order"}, order_err, 0);
    chk(!scl_oe && !sda_oe, {tag, " R6 lines released at done"}, {scl_oe, sda_oe}, 0);
    @(negedge clk);
    chk(done == 1'b0, {tag, " R6 done single"}, done, 0);
    chk(busy == 1'b0, {tag, " R6 idle after done"}, busy, 0);
    hold_on  = 1'b0;
    hold_all = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(!busy && !done && !sto && !scl_oe && !sda_oe, "R9 reset state",
        {busy, done, sto, scl_oe, sda_oe}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && !scl_oe && !sda_oe, "R9 idle after reset release",
        {busy, scl_oe, sda_oe}, 0);

    // Stretch vectors, R3 and R4 boundary at exactly 50 polls
    for (int i = 0; i < NV; i++)
      run(VEC_POLLS[i], 1'b0, VEC_FLAG[i], -1, $sformatf("vec%0d", i));

    // R4 SCL held low for the whole sequence: every pulse hits the cap
    run(0, 1'b1, 1, -1, "cap");
    repeat (5) @(negedge clk);
    chk(sto == 1'b1, "R7 flag sticky while idle", sto, 1);

    // R8 start while busy ignored (also clears R7 flag at start)
    run(0, 1'b0, 0, 40, "restart");

    // R9 reset in mid sequence
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (30) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(!busy && !scl_oe && !sda_oe, "R9 async reset mid-run",
        {busy, scl_oe, sda_oe}, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(!busy && !done && !scl_oe, "R9 idle after mid-run reset",
        {busy, done, scl_oe}, 0);
    run(0, 1'b0, 0, -1, "post_reset");

    summary();
    $finish;
  end
endmodule